// File: doc/BRIEF.md
# Adaptive Stratum Size Predictor

This block picks the instruction-count threshold for a deterministic multithreaded machine that splits execution into strata. After each stratum it looks at why that stratum closed. If it closed early because of a synchronization point, or because buffering ran out in a mode that treats that as a stratum end, the block lowers its confidence. If it ran to its full instruction budget, the block raises its confidence. Confidence is held in a small saturating counter.

A decrement on an empty counter halves the stratum size. An increment on a full counter doubles it. After a size change the counter goes back to its midpoint. Larger strata smooth out variation in the instruction mix. Smaller strata follow frequent synchronization and cut load imbalance between cores. The size is always a power of two and stays between a configured floor and ceiling.

A new size is staged when it is computed. It reaches the output only when the next execute phase begins, so the threshold never changes in the middle of a stratum. Counting instructions and ending strata are done elsewhere.

Top module: `ssp_stratum_sizer`

## Requirements
- R1: After reset the threshold is 2^INIT_LOG2 (1024 by default) and the confidence counter holds its midpoint, 2 for the default 2-bit counter.
- R2: A stratum end with `end_barrier` high lowers confidence by one in every mode.
- R3: A stratum end with `end_overflow` high lowers confidence when `run_mode` is 1 (conventional) or 2 (bounded deterministic). When `run_mode` is 0 (unbounded deterministic) or 3 (treated as 0), the overflow flag alone leaves confidence unchanged.
- R4: A stratum end with no decrementing cause and `end_full` high raises confidence by one.
- R5: While `stratum_end` is low, the cause flags and mode have no effect on confidence or on the staged size.
- R6: A decrement while confidence is 0 halves the staged size and sets confidence to the midpoint.
- R7: An increment while confidence is at its maximum (3) doubles the staged size and sets confidence to the midpoint.
- R8: The threshold is always a power of two within [2^MIN_LOG2, 2^MAX_LOG2] (64 to 16384 by default). A halve at the floor or a double at the ceiling is dropped, and confidence stays at its saturated end.
- R9: The threshold output copies the staged size only on a cycle with `exec_start` high, and it becomes visible one cycle later. At all other times it holds its value.
- R10: When `end_barrier` and `end_full` are both high, the decrement wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stratum_end | input | 1 | One-cycle strobe: a stratum has closed |
| end_barrier | input | 1 | The stratum closed on a barrier or synchronization |
| end_overflow | input | 1 | The stratum closed because buffering was exhausted |
| end_full | input | 1 | The stratum reached its full instruction budget |
| run_mode | input | 2 | 0 unbounded deterministic, 1 conventional, 2 bounded deterministic, 3 same as 0 |
| exec_start | input | 1 | One-cycle strobe: the next execute phase begins |
| threshold | output | MAX_LOG2+1 | Instruction-count threshold for the current stratum |

## Verification
The confidence counter cannot be seen directly. If it holds a wrong value, the block halves or doubles one or more strata too early or too late. That error shows at the ports only after the next `exec_start`. The scenarios therefore count exactly how many stratum ends should produce a size change, and they check the threshold on both sides of that boundary. An error in the staged exponent, or a dropped clamp, shows as a wrong or non-power-of-two threshold one cycle after the next `exec_start`. A copy that skips the staging shows up as a change before `exec_start` is pulsed.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    MODE_UNBOUNDED    = 2'd0,
    MODE_CONVENTIONAL = 2'd1,
    MODE_BOUNDED      = 2'd2,
    MODE_SPARE        = 2'd3
  } run_mode_e;

  // Modes in which running out of buffer counts against the stratum size.
  function automatic logic overflow_shrinks(input run_mode_e m);
    return (m == MODE_CONVENTIONAL) || (m == MODE_BOUNDED);
  endfunction

  // Midpoint of an n-bit confidence counter.
  function automatic int unsigned conf_mid(input int unsigned n);
    return 32'd1 << (n - 1);
  endfunction

  // Top value of an n-bit confidence counter.
  function automatic int unsigned conf_top(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

endpackage

// File: rtl/ssp_cause_decode.sv
module ssp_cause_decode
  import ssp_pkg::*;
(
  input  logic      stratum_end,
  input  logic      end_barrier,
  input  logic      end_overflow,
  input  logic      end_full,
  input  run_mode_e mode,
  output logic      dec_req,
  output logic      inc_req
);

  logic shrink_cause;

  always_comb begin
    shrink_cause = end_barrier || (end_overflow && overflow_shrinks(mode));
    dec_req      = stratum_end && shrink_cause;
    inc_req      = stratum_end && !shrink_cause && end_full;
  end

endmodule

// File: rtl/ssp_conf_ctr.sv
module ssp_conf_ctr
  import ssp_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_req,
  input  logic             inc_req,
  input  logic             size_moved,
  output logic [CNT_W-1:0] conf,
  output logic             lo_sat,
  output logic             hi_sat
);

  localparam logic [CNT_W-1:0] MID = CNT_W'(conf_mid(CNT_W));
  localparam logic [CNT_W-1:0] TOP = CNT_W'(conf_top(CNT_W));

  logic at_low, at_high;

  always_comb begin
    at_low = (conf == '0);
    at_high = (conf == TOP);
    lo_sat = dec_req && at_low;
    hi_sat = inc_req && at_high;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conf <= MID;
    end else if (size_moved) begin
      conf <= MID;
    end else if (dec_req && !at_low) begin
      conf <= conf - 1'b1;
    end else if (inc_req && !at_high) begin
      conf <= conf + 1'b1;
    end
  end

endmodule

// File: rtl/ssp_size_reg.sv
module ssp_size_reg #(
  parameter int MIN_LOG2  = 6,
  parameter int MAX_LOG2  = 14,
  parameter int INIT_LOG2 = 10,
  parameter int EXP_W     = 4,
  parameter int THR_W     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shrink_req,
  input  logic             grow_req,
  input  logic             exec_start,
  output logic             size_moved,
  output logic [EXP_W-1:0] pending_exp,
  output logic [THR_W-1:0] threshold
);

  localparam logic [EXP_W-1:0] EXP_MIN  = EXP_W'(MIN_LOG2);
  localparam logic [EXP_W-1:0] EXP_MAX  = EXP_W'(MAX_LOG2);
  localparam logic [EXP_W-1:0] EXP_INIT = EXP_W'(INIT_LOG2);

  logic [EXP_W-1:0] active_exp;
  logic             shrink_go, grow_go;

  always_comb begin
    shrink_go  = shrink_req && (pending_exp > EXP_MIN);
    grow_go    = grow_req && (pending_exp < EXP_MAX);
    size_moved = shrink_go || grow_go;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_exp <= EXP_INIT;
    end else if (shrink_go) begin
      pending_exp <= pending_exp - 1'b1;
    end else if (grow_go) begin
      pending_exp <= pending_exp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_exp <= EXP_INIT;
    end else if (exec_start) begin
      active_exp <= pending_exp;
    end
  end

  assign threshold = THR_W'(1) << active_exp;

endmodule

// File: rtl/ssp_stratum_sizer.sv
module ssp_stratum_sizer
  import ssp_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int MIN_LOG2  = 6,
  parameter int MAX_LOG2  = 14,
  parameter int INIT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stratum_end,
  input  logic              end_barrier,
  input  logic              end_overflow,
  input  logic              end_full,
  input  logic [1:0]        run_mode,
  input  logic              exec_start,
  output logic [MAX_LOG2:0] threshold
);

  localparam int EXP_W = $clog2(MAX_LOG2 + 1);
  localparam int THR_W = MAX_LOG2 + 1;

  logic             dec_req, inc_req;
  logic             lo_sat, hi_sat, size_moved;
  logic [CNT_W-1:0] conf;
  logic [EXP_W-1:0] pending_exp;
  run_mode_e        mode;

  assign mode = run_mode_e'(run_mode);

  ssp_cause_decode u_dec (
    .stratum_end (stratum_end),
    .end_barrier (end_barrier),
    .end_overflow(end_overflow),
    .end_full    (end_full),
    .mode        (mode),
    .dec_req     (dec_req),
    .inc_req     (inc_req)
  );

  ssp_conf_ctr #(.CNT_W(CNT_W)) u_conf (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_req   (dec_req),
    .inc_req   (inc_req),
    .size_moved(size_moved),
    .conf      (conf),
    .lo_sat    (lo_sat),
    .hi_sat    (hi_sat)
  );

  ssp_size_reg #(
    .MIN_LOG2 (MIN_LOG2),
    .MAX_LOG2 (MAX_LOG2),
    .INIT_LOG2(INIT_LOG2),
    .EXP_W    (EXP_W),
    .THR_W    (THR_W)
  ) u_size (
    .clk        (clk),
    .rst_n      (rst_n),
    .shrink_req (lo_sat),
    .grow_req   (hi_sat),
    .exec_start (exec_start),
    .size_moved (size_moved),
    .pending_exp(pending_exp),
    .threshold  (threshold)
  );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int CNT_W    = 2,
  parameter int EXP_W    = 4,
  parameter int MIN_LOG2 = 6,
  parameter int MAX_LOG2 = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stratum_end,
  input logic              end_barrier,
  input logic              end_overflow,
  input logic              end_full,
  input logic [1:0]        run_mode,
  input logic              exec_start,
  input logic [MAX_LOG2:0] threshold,
  input logic [CNT_W-1:0]  conf,
  input logic [EXP_W-1:0]  pending_exp,
  input logic              inc_req
);

  localparam logic [CNT_W-1:0]  C_MID   = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0]  C_TOP   = CNT_W'((1 << CNT_W) - 1);
  localparam logic [EXP_W-1:0]  E_MIN   = EXP_W'(MIN_LOG2);
  localparam logic [EXP_W-1:0]  E_MAX   = EXP_W'(MAX_LOG2);
  localparam logic [MAX_LOG2:0] THR_LO  = (MAX_LOG2+1)'(1) << MIN_LOG2;
  localparam logic [MAX_LOG2:0] THR_HI  = (MAX_LOG2+1)'(1) << MAX_LOG2;

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_start |=> $stable(threshold)); // R9

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !stratum_end |=> ($stable(conf) && $stable(pending_exp))); // R5

  AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(threshold) == 1) && (threshold >= THR_LO) && (threshold <= THR_HI)); // R8

  AST_BARRIER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (stratum_end && end_barrier && conf != '0) |=> (conf == CNT_W'($past(conf) - 1'b1))); // R2

  AST_HALVE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stratum_end && end_barrier && conf == '0 && pending_exp > E_MIN)
      |=> (pending_exp == EXP_W'($past(pending_exp) - 1'b1)) && (conf == C_MID)); // R6

  AST_DOUBLE_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && conf == C_TOP && pending_exp < E_MAX)
      |=> (pending_exp == EXP_W'($past(pending_exp) + 1'b1)) && (conf == C_MID)); // R7

  AST_OVF_UNBOUNDED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stratum_end && end_overflow && !end_barrier && !end_full && run_mode[0] == run_mode[1])
      |=> $stable(conf)); // R3

endmodule

bind ssp_stratum_sizer ssp_checker #(
  .CNT_W   (CNT_W),
  .EXP_W   (EXP_W),
  .MIN_LOG2(MIN_LOG2),
  .MAX_LOG2(MAX_LOG2)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stratum_end (stratum_end),
  .end_barrier (end_barrier),
  .end_overflow(end_overflow),
  .end_full    (end_full),
  .run_mode    (run_mode),
  .exec_start  (exec_start),
  .threshold   (threshold),
  .conf        (conf),
  .pending_exp (pending_exp),
  .inc_req     (inc_req)
);

// File: tb/sim_ssp_stratum_sizer.sv
`timescale 1ns/1ps
module sim_ssp_stratum_sizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stratum_end = 1'b0;
  logic        end_barrier = 1'b0;
  logic        end_overflow = 1'b0;
  logic        end_full = 1'b0;
  logic [1:0]  run_mode = 2'd0;
  logic        exec_start = 1'b0;
  logic [14:0] threshold;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssp_stratum_sizer u0 (
    .clk(clk), .rst_n(rst_n), .stratum_end(stratum_end),
    .end_barrier(end_barrier), .end_overflow(end_overflow),
    .end_full(end_full), .run_mode(run_mode),
    .exec_start(exec_start), .threshold(threshold)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_vec++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s: threshold %0d, expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic end_stratum(input bit b, input bit o, input bit f, input logic [1:0] m);
    @(negedge clk);
    stratum_end = 1'b1; end_barrier = b; end_overflow = o; end_full = f; run_mode = m;
    @(negedge clk);
    stratum_end = 1'b0; end_barrier = 1'b0; end_overflow = 1'b0; end_full = 1'b0;
  endtask

  task automatic begin_exec();
    @(negedge clk); exec_start = 1'b1;
    @(negedge clk); exec_start = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 reset threshold", int'(threshold), 1024);
  endtask

  // R4 / R7 / R9: two full strata from midpoint double; held until exec_start
  task automatic t_grow();
    do_reset();
    end_stratum(0, 0, 1, 2'd0);
    begin_exec();
    check("R4 one increment no change", int'(threshold), 1024);
    end_stratum(0, 0, 1, 2'd0);
    repeat (3) @(negedge clk);
    check("R9 staged size not visible yet", int'(threshold), 1024);
    begin_exec();
    check("R7 double after saturating high", int'(threshold), 2048);
  endtask

  // R2 / R6: barrier ends in unbounded mode, three needed from midpoint
  task automatic t_shrink();
    do_reset();
    end_stratum(1, 0, 0, 2'd0);
    end_stratum(1, 0, 0, 2'd0);
    begin_exec();
    check("R2 two decrements no halve", int'(threshold), 1024);
    end_stratum(1, 0, 0, 2'd0);
    begin_exec();
    check("R6 halve after saturating low", int'(threshold), 512);
    end_stratum(1, 0, 0, 2'd0);
    end_stratum(1, 0, 0, 2'd0);
    begin_exec();
    check("R6 recentered to midpoint", int'(threshold), 512);
  endtask

  // R3: overflow shrinks in modes 1 and 2 only
  task automatic t_overflow_modes();
    for (int m = 1; m <= 2; m++) begin
      do_reset();
      repeat (3) end_stratum(0, 1, 0, 2'(m));
      begin_exec();
      check($sformatf("R3 overflow mode %0d halves", m), int'(threshold), 512);
    end
    do_reset();
    repeat (5) end_stratum(0, 1, 0, 2'd0);
    repeat (5) end_stratum(0, 1, 0, 2'd3);
    end_stratum(0, 0, 1, 2'd0);
    begin_exec();
    check("R3 overflow ignored in unbounded mode", int'(threshold), 1024);
    end_stratum(0, 1, 1, 2'd0);
    begin_exec();
    check("R3 unbounded overflow+full increments", int'(threshold), 2048);
  endtask

  // R5: flags without the strobe do nothing
  task automatic t_idle_flags();
    do_reset();
    @(negedge clk);
    end_barrier = 1'b1; end_overflow = 1'b1; run_mode = 2'd1;
    repeat (6) @(negedge clk);
    end_barrier = 1'b0; end_overflow = 1'b0; end_full = 1'b1;
    repeat (6) @(negedge clk);
    end_full = 1'b0;
    begin_exec();
    check("R5 flags ignored without strobe", int'(threshold), 1024);
    end_stratum(0, 0, 1, 2'd1);
    end_stratum(0, 0, 1, 2'd1);
    begin_exec();
    check("R5 counter still at midpoint", int'(threshold), 2048);
  endtask

  // R10: barrier with full decrements
  task automatic t_priority();
    do_reset();
    repeat (3) end_stratum(1, 0, 1, 2'd2);
    begin_exec();
    check("R10 barrier beats full", int'(threshold), 512);
  endtask

  // R8: floor at 64, counter stays at 0
  task automatic t_floor();
    do_reset();
    repeat (12) end_stratum(1, 0, 0, 2'd1);
    begin_exec();
    check("R8 reached floor", int'(threshold), 64);
    repeat (3) end_stratum(1, 0, 0, 2'd1);
    begin_exec();
    check("R8 halve at floor dropped", int'(threshold), 64);
    repeat (3) end_stratum(0, 0, 1, 2'd1);
    begin_exec();
    check("R8 counter stayed at low end", int'(threshold), 64);
    end_stratum(0, 0, 1, 2'd1);
    begin_exec();
    check("R8 double from floor", int'(threshold), 128);
  endtask

  // R8: ceiling at 16384, counter stays at 3
  task automatic t_ceiling();
    do_reset();
    repeat (8) end_stratum(0, 0, 1, 2'd0);
    begin_exec();
    check("R8 reached ceiling", int'(threshold), 16384);
    repeat (2) end_stratum(0, 0, 1, 2'd0);
    begin_exec();
    check("R8 double at ceiling dropped", int'(threshold), 16384);
    repeat (3) end_stratum(1, 0, 0, 2'd0);
    begin_exec();
    check("R8 counter stayed at high end", int'(threshold), 16384);
    end_stratum(1, 0, 0, 2'd0);
    begin_exec();
    check("R8 halve from ceiling", int'(threshold), 8192);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    t_reset_state();
    t_grow();
    t_shrink();
    t_overflow_modes();
    t_idle_flags();
    t_priority();
    t_floor();
    t_ceiling();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung, expected done");
      summary();
      $finish;
    end
  end

endmodule